// File: doc/BRIEF.md
# Serial Bus Low-Power Wake Controller

This block sits beside a byte-level serial bus link controller and decides when that controller may sleep and how it wakes. The CPU requests sleep with a WAIT pulse or a STOP pulse. A wait-to-stop control bit turns a WAIT pulse into the deep stop state. A request that arrives while a transmission is still running is held until the transmitter goes idle. In the light wait state the operating clock keeps running. In stop state the clock enable drops.

The receive line passes through a two-stage synchroniser. Bus activity then ends the sleep. A wait-state wake raises a maskable interrupt, but only if interrupts were enabled when the block went to sleep. A stop-state wake raises a non-maskable interrupt. After a stop-state wake the block waits for a settling count of slow reference ticks before it reports the clock ready again.

On every wake the block also reports whether the byte that caused the wake-up can be trusted. That flag depends on how sleep was entered, on whether end-of-frame had been seen, and on whether a message was already arriving at the moment of entry. Both interrupt outputs are levels, and they are held until the CPU acknowledges them.

Top module: `buswake_top`

## Requirements
- R1: After reset, powerMode is 0 (run), opClkEn and clkReady are 1, and maskIrq, nmiIrq and wakeValid are 0. powerMode encodes run=0, wait=1, stop=2, settle=3.
- R2: In run, a waitReq pulse with waitToStop=0 and txBusy=0 moves powerMode to 1 at the next edge. opClkEn and clkReady stay 1 throughout wait.
- R3: In run, a stopReq pulse, or a waitReq pulse with waitToStop=1, moves powerMode to 2 at the next edge (with txBusy=0). In stop, opClkEn and clkReady are 0. stopReq takes precedence over waitReq.
- R4: A request that arrives while txBusy=1 is held, and the mode stays at run. The held request takes effect at the first edge at which txBusy=0. A newer request replaces a held one.
- R5: In wait, any change of the synchronised receive level returns powerMode to 0 and sets wakeValid to 1. maskIrq is set only if intEnable was 1 at the edge where wait was entered. A change on rxLine before edge k acts at edge k+2.
- R6: In stop, a low-to-high change of the synchronised line moves powerMode to 3, sets nmiIrq and keeps opClkEn at 1. A high-to-low change does not wake the block, unless R9 applies.
- R7: In settle, clkReady is 0. The block returns to run at the edge of the SETTLE_TICKS-th refTick counted in settle, and clkReady then rises.
- R8: On a stop wake, wakeValid becomes 0 if stop was entered through stopReq. If stop was entered through waitReq, wakeValid takes the eofSeen value sampled at entry.
- R9: If rxBusy was 1 at stop entry, any synchronised edge wakes the block, and wakeValid becomes 0.
- R10: intClear clears maskIrq and nmiIrq at the next edge. A set at the same edge wins.
- R11: waitReq and stopReq have no effect outside run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refTick | input | 1 | One-cycle strobe from the slow reference clock |
| waitReq | input | 1 | CPU WAIT event pulse |
| stopReq | input | 1 | CPU STOP event pulse |
| waitToStop | input | 1 | Makes WAIT enter stop |
| intEnable | input | 1 | Maskable interrupt enable |
| txBusy | input | 1 | Transmission in progress |
| rxLine | input | 1 | Raw bus receive line, high is active |
| rxBusy | input | 1 | Receiver mid-message |
| eofSeen | input | 1 | End-of-frame detected |
| intClear | input | 1 | Acknowledge of both interrupts |
| powerMode | output | 2 | 0 run, 1 wait, 2 stop, 3 settle |
| opClkEn | output | 1 | Operating clock enable |
| clkReady | output | 1 | Operating clock stable |
| maskIrq | output | 1 | Maskable wake interrupt level |
| nmiIrq | output | 1 | Non-maskable wake interrupt level |
| wakeValid | output | 1 | Waking byte trustworthy |

## Verification
The bench builds the block with SYNC_STAGES=2 and SETTLE_TICKS=5, and drives refTick on every third clock. With these values each settle period ends within about fifteen cycles, so every stop-state wake in the run goes all the way back to run, and each exit edge is compared cycle by cycle. The small tick count also leaves room for many entries in a short run. These cover every validity combination (STOP entry, WAIT entry with and without end-of-frame, and entry while receiving), a request deferred by txBusy, and a falling edge that must be ignored.

// File: rtl/buswake_pkg.sv
package buswake_pkg;
  typedef enum logic [1:0] {
    PM_RUN    = 2'd0,
    PM_WAIT   = 2'd1,
    PM_STOP   = 2'd2,
    PM_SETTLE = 2'd3
  } pmode_e;

  typedef enum logic [1:0] {
    EK_NONE   = 2'd0,
    EK_WAIT   = 2'd1,
    EK_STOP_W = 2'd2,
    EK_STOP_S = 2'd3
  } entry_e;

  typedef struct packed {
    logic cntClear;
    logic cntStep;
    logic setMask;
    logic setNmi;
    logic loadValid;
    logic validVal;
  } dpStrobe_t;
endpackage

// File: rtl/buswake_dp.sv
module buswake_dp
  import buswake_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int SETTLE_TICKS = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      rxLine,
  input  logic      intClear,
  input  dpStrobe_t stb,
  output logic      rxRise,
  output logic      rxToggle,
  output logic      cntDone,
  output logic      maskIrq,
  output logic      nmiIrq,
  output logic      wakeValid
);
  localparam int CNT_W = (SETTLE_TICKS > 1) ? $clog2(SETTLE_TICKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_TICKS - 1);

  logic [SYNC_STAGES:0] chain;
  logic                 syncLvl;
  logic                 prevLvl;
  logic [CNT_W-1:0]     cnt;

  // synchroniser plus one history stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[SYNC_STAGES-1:0], rxLine};
  end

  assign syncLvl  = chain[SYNC_STAGES-1];
  assign prevLvl  = chain[SYNC_STAGES];
  assign rxRise   = syncLvl & ~prevLvl;
  assign rxToggle = syncLvl ^ prevLvl;

  // clock settling counter, counts reference ticks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cnt <= '0;
    else if (stb.cntClear) cnt <= '0;
    else if (stb.cntStep)  cnt <= cnt + CNT_W'(1);
  end

  assign cntDone = (cnt == CNT_LAST);

  // interrupt levels, a set wins over a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskIrq <= 1'b0;
      nmiIrq  <= 1'b0;
    end else begin
      if (stb.setMask)   maskIrq <= 1'b1;
      else if (intClear) maskIrq <= 1'b0;
      if (stb.setNmi)    nmiIrq  <= 1'b1;
      else if (intClear) nmiIrq  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              wakeValid <= 1'b0;
    else if (stb.loadValid) wakeValid <= stb.validVal;
  end
endmodule

// File: rtl/buswake_ctrl.sv
module buswake_ctrl
  import buswake_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      waitReq,
  input  logic      stopReq,
  input  logic      waitToStop,
  input  logic      intEnable,
  input  logic      rxBusy,
  input  logic      eofSeen,
  input  logic      txBusy,
  input  logic      refTick,
  input  logic      rxRise,
  input  logic      rxToggle,
  input  logic      cntDone,
  output pmode_e    mode,
  output dpStrobe_t stb
);
  pmode_e modeQ, modeD;
  entry_e pendQ, pendD, viaQ, reqKind, effKind;
  logic   eofQ, busyQ, ieQ;
  logic   enter, stopWake;

  always_comb begin
    if (stopReq)      reqKind = EK_STOP_S;
    else if (waitReq) reqKind = waitToStop ? EK_STOP_W : EK_WAIT;
    else              reqKind = EK_NONE;
    effKind  = (reqKind != EK_NONE) ? reqKind : pendQ;
    stopWake = busyQ ? rxToggle : rxRise;
  end

  always_comb begin
    modeD = modeQ;
    pendD = pendQ;
    enter = 1'b0;
    stb   = '0;
    unique case (modeQ)
      PM_RUN: begin
        if (effKind != EK_NONE) begin
          if (txBusy) begin
            pendD = effKind;
          end else begin
            pendD = EK_NONE;
            enter = 1'b1;
            modeD = (effKind == EK_WAIT) ? PM_WAIT : PM_STOP;
          end
        end
      end
      PM_WAIT: begin
        if (rxToggle) begin
          modeD         = PM_RUN;
          stb.setMask   = ieQ;
          stb.loadValid = 1'b1;
          stb.validVal  = 1'b1;
        end
      end
      PM_STOP: begin
        if (stopWake) begin
          modeD         = PM_SETTLE;
          stb.cntClear  = 1'b1;
          stb.setNmi    = 1'b1;
          stb.loadValid = 1'b1;
          stb.validVal  = ~busyQ & (viaQ == EK_STOP_W) & eofQ;
        end
      end
      PM_SETTLE: begin
        if (refTick) begin
          if (cntDone) modeD = PM_RUN;
          else         stb.cntStep = 1'b1;
        end
      end
      default: modeD = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= PM_RUN;
      pendQ <= EK_NONE;
      viaQ  <= EK_NONE;
      eofQ  <= 1'b0;
      busyQ <= 1'b0;
      ieQ   <= 1'b0;
    end else begin
      modeQ <= modeD;
      pendQ <= pendD;
      if (enter) begin
        viaQ  <= effKind;
        eofQ  <= eofSeen;
        busyQ <= rxBusy;
        ieQ   <= intEnable;
      end
    end
  end

  assign mode = modeQ;
endmodule

// File: rtl/buswake_top.sv
module buswake_top
  import buswake_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int SETTLE_TICKS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       refTick,
  input  logic       waitReq,
  input  logic       stopReq,
  input  logic       waitToStop,
  input  logic       intEnable,
  input  logic       txBusy,
  input  logic       rxLine,
  input  logic       rxBusy,
  input  logic       eofSeen,
  input  logic       intClear,
  output logic [1:0] powerMode,
  output logic       opClkEn,
  output logic       clkReady,
  output logic       maskIrq,
  output logic       nmiIrq,
  output logic       wakeValid
);
  pmode_e    modeW;
  dpStrobe_t stbW;
  logic      rxRiseW, rxToggleW, cntDoneW;

  buswake_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .waitReq(waitReq), .stopReq(stopReq),
    .waitToStop(waitToStop), .intEnable(intEnable), .rxBusy(rxBusy),
    .eofSeen(eofSeen), .txBusy(txBusy), .refTick(refTick),
    .rxRise(rxRiseW), .rxToggle(rxToggleW), .cntDone(cntDoneW),
    .mode(modeW), .stb(stbW)
  );

  buswake_dp #(.SYNC_STAGES(SYNC_STAGES), .SETTLE_TICKS(SETTLE_TICKS)) u_dp (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .intClear(intClear),
    .stb(stbW), .rxRise(rxRiseW), .rxToggle(rxToggleW), .cntDone(cntDoneW),
    .maskIrq(maskIrq), .nmiIrq(nmiIrq), .wakeValid(wakeValid)
  );

  assign powerMode = modeW;
  assign opClkEn   = (modeW != PM_STOP);
  assign clkReady  = (modeW == PM_RUN) || (modeW == PM_WAIT);
endmodule

// File: rtl/buswake_chk.sv
module buswake_chk
  import buswake_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       txBusy,
  input logic       refTick,
  input logic [1:0] powerMode,
  input logic       nmiIrq,
  input logic       wakeValid
);
  // R4
  no_entry_during_tx_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(powerMode) == PM_RUN && powerMode != PM_RUN) |-> !$past(txBusy));

  // R6
  nmi_on_stop_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(powerMode) == PM_STOP && powerMode == PM_SETTLE) |-> nmiIrq);

  // R6
  nmi_rise_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nmiIrq) |-> ($past(powerMode) == PM_STOP));

  // R7
  settle_exit_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(powerMode) == PM_SETTLE && powerMode == PM_RUN) |-> $past(refTick));

  // R7
  stop_leaves_to_settle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(powerMode) == PM_STOP) |-> (powerMode == PM_STOP || powerMode == PM_SETTLE));

  // R5
  wait_wake_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(powerMode) == PM_WAIT && powerMode == PM_RUN) |-> wakeValid);
endmodule

bind buswake_top buswake_chk u_chk (
  .clk(clk), .rstN(rstN), .txBusy(txBusy), .refTick(refTick),
  .powerMode(powerMode), .nmiIrq(nmiIrq), .wakeValid(wakeValid)
);

// File: tb/tb_buswake_top.sv
module tb_buswake_top;
  localparam int TICKS = 5;

  logic clk = 0, rstN = 0, refTick = 0, waitReq = 0, stopReq = 0;
  logic waitToStop = 0, intEnable = 0, txBusy = 0, rxLine = 0;
  logic rxBusy = 0, eofSeen = 0, intClear = 0;
  logic [1:0] powerMode;
  logic opClkEn, clkReady, maskIrq, nmiIrq, wakeValid;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  buswake_top #(.SYNC_STAGES(2), .SETTLE_TICKS(TICKS)) dut (
    .clk(clk), .rstN(rstN), .refTick(refTick), .waitReq(waitReq),
    .stopReq(stopReq), .waitToStop(waitToStop), .intEnable(intEnable),
    .txBusy(txBusy), .rxLine(rxLine), .rxBusy(rxBusy), .eofSeen(eofSeen),
    .intClear(intClear), .powerMode(powerMode), .opClkEn(opClkEn),
    .clkReady(clkReady), .maskIrq(maskIrq), .nmiIrq(nmiIrq),
    .wakeValid(wakeValid)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference tick every third cycle
  int tickCnt = 0;
  always @(negedge clk) begin
    tickCnt = (tickCnt + 1) % 3;
    refTick <= (tickCnt == 0);
  end

  // behavioural reference model
  int mMode = 0, mPend = 0, mVia = 0, mEof = 0, mBusy = 0, mIe = 0, mCnt = 0;
  int mMask = 0, mNmi = 0, mValid = 0;
  int lineHist[$] = '{0, 0, 0};

  always @(posedge clk) begin
    if (!rstN) begin
      mMode = 0; mPend = 0; mVia = 0; mEof = 0; mBusy = 0; mIe = 0; mCnt = 0;
      mMask = 0; mNmi = 0; mValid = 0; lineHist = '{0, 0, 0};
    end else begin
      int kind, anyE, rise, setM, setN;
      anyE = (lineHist[1] != lineHist[2]);
      rise = (lineHist[1] == 1 && lineHist[2] == 0);
      setM = 0; setN = 0;
      if (mMode == 0) begin
        kind = stopReq ? 3 : (waitReq ? (waitToStop ? 2 : 1) : mPend);
        if (kind != 0) begin
          if (txBusy) mPend = kind;
          else begin
            mPend = 0; mMode = (kind == 1) ? 1 : 2; mVia = kind;
            mEof = eofSeen; mBusy = rxBusy; mIe = intEnable;
          end
        end
      end else if (mMode == 1) begin
        if (anyE) begin mMode = 0; setM = mIe; mValid = 1; end
      end else if (mMode == 2) begin
        if (mBusy ? anyE : rise) begin
          mMode = 3; mCnt = 0; setN = 1;
          mValid = (mBusy == 0 && mVia == 2) ? mEof : 0;
        end
      end else begin
        if (refTick) begin
          if (mCnt == TICKS - 1) mMode = 0; else mCnt++;
        end
      end
      if (setM) mMask = 1; else if (intClear) mMask = 0;
      if (setN) mNmi = 1; else if (intClear) mNmi = 0;
      void'(lineHist.pop_back());
      lineHist.push_front(int'(rxLine));
    end
  end

  always @(posedge clk) begin
    #2;
    if (rstN && !done) begin
      chk("R2 R3 R4 R5 R6 R7 R11 model powerMode", powerMode, mMode);
      chk("R2 R3 model opClkEn", opClkEn, mMode != 2);
      chk("R7 model clkReady", clkReady, mMode < 2);
      chk("R5 R10 model maskIrq", maskIrq, mMask);
      chk("R6 R10 model nmiIrq", nmiIrq, mNmi);
      chk("R8 R9 model wakeValid", wakeValid, mValid);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic pulseWait();
    waitReq = 1; cyc(1); waitReq = 0;
  endtask
  task automatic pulseStop();
    stopReq = 1; cyc(1); stopReq = 0;
  endtask
  task automatic setLine(input logic v);
    rxLine = v; cyc(3);
  endtask
  task automatic waitRun(input string tag);
    for (int i = 0; i < 40 && powerMode != 0; i++) cyc(1);
    chk(tag, powerMode, 0);
    chk(tag, clkReady, 1);
  endtask
  task automatic clearIrq();
    intClear = 1; cyc(1); intClear = 0;
  endtask

  initial begin
    #(8 * 20000);
    bad++; total++;
    $display("FAIL R7 watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(3);
    rstN = 1;
    cyc(1);
    // R1 reset state
    chk("R1 powerMode", powerMode, 0);
    chk("R1 opClkEn", opClkEn, 1);
    chk("R1 clkReady", clkReady, 1);
    chk("R1 maskIrq", maskIrq, 0);
    chk("R1 nmiIrq", nmiIrq, 0);
    chk("R1 wakeValid", wakeValid, 0);

    // R2 wait entry, R5 wake with interrupt enabled
    intEnable = 1; pulseWait();
    chk("R2 wait entered", powerMode, 1);
    chk("R2 clock kept", opClkEn, 1);
    intEnable = 0;
    stopReq = 1; cyc(1); stopReq = 0;
    chk("R11 stop ignored in wait", powerMode, 1);
    setLine(1);
    chk("R5 wake to run", powerMode, 0);
    chk("R5 maskIrq set", maskIrq, 1);
    chk("R5 wakeValid", wakeValid, 1);
    clearIrq();
    chk("R10 maskIrq cleared", maskIrq, 0);

    // R5 wake with interrupt disabled, falling edge
    pulseWait();
    setLine(0);
    chk("R5 wake no irq mode", powerMode, 0);
    chk("R5 maskIrq stays low", maskIrq, 0);

    // R3 stop by stopReq, R8 invalid
    eofSeen = 1; pulseStop();
    chk("R3 stop entered", powerMode, 2);
    chk("R3 clock gated", opClkEn, 0);
    chk("R3 not ready", clkReady, 0);
    pulseWait();
    chk("R11 wait ignored in stop", powerMode, 2);
    setLine(1);
    chk("R6 settle", powerMode, 3);
    chk("R6 nmiIrq", nmiIrq, 1);
    chk("R7 not ready in settle", clkReady, 0);
    chk("R8 stopReq entry invalid", wakeValid, 0);
    waitRun("R7 settle done");
    clearIrq();
    chk("R10 nmiIrq cleared", nmiIrq, 0);

    // R3 stop via wait with eof, R6 falling edge ignored
    waitToStop = 1; eofSeen = 1; pulseWait(); eofSeen = 0;
    chk("R3 wait-to-stop", powerMode, 2);
    setLine(0); cyc(3);
    chk("R6 falling ignored", powerMode, 2);
    setLine(1);
    chk("R6 rising wakes", powerMode, 3);
    chk("R8 eof entry valid", wakeValid, 1);
    waitRun("R7 settle done 2");
    clearIrq();

    // R8 stop via wait without eof
    pulseWait();
    setLine(0); setLine(1);
    chk("R8 no eof invalid", wakeValid, 0);
    waitRun("R7 settle done 3");
    clearIrq();

    // R4 deferred entry
    waitToStop = 0; txBusy = 1; pulseWait();
    cyc(4);
    chk("R4 held while tx busy", powerMode, 0);
    txBusy = 0; cyc(1);
    chk("R4 entered after tx", powerMode, 1);
    setLine(0);
    chk("R4 woke", powerMode, 0);

    // R9 entry while receiving
    setLine(1);
    waitToStop = 1; eofSeen = 1; rxBusy = 1; pulseWait();
    rxBusy = 0; eofSeen = 0;
    chk("R9 stop entered", powerMode, 2);
    setLine(0);
    chk("R9 any edge wakes", powerMode, 3);
    chk("R9 invalid", wakeValid, 0);
    waitRun("R7 settle done 4");
    cyc(4);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule